// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel flash model with a 16-bit address. It watches the active-low chip enable, output enable and write enable lines, which are sampled on the system clock. From them it forms bus write cycles and follows the multi-cycle unlock-and-command sequences. It then steers the device between normal read, byte program, chip erase, identification mode and boot-sector lockout.

The block issues three kinds of output. A one-cycle program request carries the captured address and data. A one-cycle erase request starts a chip erase. Two level flags show identification mode and a sticky boot-sector lock. While identification mode is active, the block also drives the identification bytes for bus reads.

The storage array, program and erase timing, and the status polling bits belong to a separate engine. That engine reports back through `busy`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, `id_mode`, `boot_locked`, `prog_start`, `erase_start` and `id_dout_en` are all 0, and the sequence tracker is idle.
- R2: A bus write is the interval in which ce_n and we_n are both low and oe_n is high. The address is taken in the first sampled cycle of that interval. The data is taken in its last sampled cycle.
- R3: A write attempt made while oe_n is low is not a write and has no effect on the command sequence.
- R4: The writes AA@5555, 55@2AAA, A0@5555 followed by a fourth write to any address produce exactly one `prog_start` pulse. The pulse carries the fourth write's address and data.
- R5: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 produce exactly one `erase_start` pulse. `prog_start` and `erase_start` never pulse together.
- R6: The same six-write sequence ending in 40@5555 sets `boot_locked`. Only reset clears it, and no later command clears it. An erase still pulses `erase_start`, and the engine reads `boot_locked` to spare the boot sector.
- R7: While `boot_locked` is 1, a program request to an address at or below 1FFF produces no pulse. A program request above 1FFF still produces one.
- R8: The code 90 written as the third write (to 5555) sets `id_mode`. While `id_mode` is 1 and a read is active (ce_n and oe_n low, we_n high), `id_dout_en` is 1. In that state `id_dout` is 1F at address 0000, 03 at 0001, and {7'b0, boot_locked} at 0002, and 00 at any other address. Outside identification mode, `id_dout_en` and `id_dout` are 0.
- R9: `id_mode` is cleared either by AA@5555, 55@2AAA, F0@5555, or by a single write of F0 to any address while the tracker is idle.
- R10: A write that departs from the expected pattern returns the tracker to idle, and no operation starts. A following command-code write on its own then does nothing.
- R11: While `busy` is 1, completed writes are ignored and the tracker keeps its position. Identification reads are still answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, synchronous to clk |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 16 | Bus address |
| din | input | 8 | Bus write data |
| busy | input | 1 | Program/erase engine running |
| prog_start | output | 1 | One-cycle byte program request |
| prog_addr | output | 16 | Address of the program request |
| prog_data | output | 8 | Data of the program request |
| erase_start | output | 1 | One-cycle chip erase request |
| id_mode | output | 1 | Identification mode active |
| boot_locked | output | 1 | Boot sector permanently protected |
| id_dout | output | 8 | Identification read data |
| id_dout_en | output | 1 | Identification data being driven |

## Verification
The hardest case to reach from the ports is a locked boot sector meeting a program request. Getting there takes a complete six-write lockout, then a fresh four-write program sequence aimed at both sides of the 1FFF boundary. The bench builds this case out of whole sequences. It confirms the lock through an identification read of address 0002. The busy interaction is also driven partway through a sequence: junk writes arrive while `busy` is held, and the sequence is then completed once `busy` drops. This shows that the tracker held its position.

// File: rtl/flash_cmd_pkg.sv
// Shared types and command codes for the flash command decoder.
// Assumes a byte-wide data bus; codes are fixed by the command protocol.
package flash_cmd_pkg;

    // Position inside a command sequence
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PROG,
        ST_ERS3,
        ST_ERS4,
        ST_ERS5
    } seq_state_e;

    localparam logic [7:0] CODE_UNL1  = 8'hAA;
    localparam logic [7:0] CODE_UNL2  = 8'h55;
    localparam logic [7:0] CODE_PROG  = 8'hA0;
    localparam logic [7:0] CODE_IDIN  = 8'h90;
    localparam logic [7:0] CODE_IDOUT = 8'hF0;
    localparam logic [7:0] CODE_EXT   = 8'h80;
    localparam logic [7:0] CODE_ERASE = 8'h10;
    localparam logic [7:0] CODE_LOCK  = 8'h40;

endpackage

// File: rtl/flash_wr_capture.sv
// Turns sampled bus strobes into single write events.
// A write window is ce_n and we_n low with oe_n high; the address is taken
// on the window's first cycle, the data on its last. Assumes the strobes
// are already synchronous to clk.
module flash_wr_capture #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic wr_act;
    logic act_q;

    // Write window qualifier
    always_comb wr_act = !ce_n && !we_n && oe_n;

    // Latch address at window start, data while open, strobe at window end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            act_q  <= wr_act;
            wr_stb <= act_q && !wr_act;
            if (wr_act && !act_q) wr_addr <= addr;
            if (wr_act)           wr_data <= din;
        end
    end

endmodule

// File: rtl/flash_seq_fsm.sv
// Follows the unlock-and-command write sequences and raises the
// program/erase requests, the identification flag and the sticky lock.
// Assumes one wr_stb per completed bus write; writes seen while busy
// are discarded without moving the tracker.
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] UNL_ADDR_A = 16'h5555,
    parameter logic [ADDR_W-1:0] UNL_ADDR_B = 16'h2AAA,
    parameter logic [ADDR_W-1:0] BOOT_LAST  = 16'h1FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              prog_start,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_start,
    output logic              id_mode,
    output logic              boot_locked
);

    seq_state_e state;
    logic       hit_unl1;
    logic       hit_unl2;
    logic       at_cmd;
    logic       in_boot;

    // Pattern matches for the current write
    always_comb begin
        hit_unl1 = (wr_addr == UNL_ADDR_A) && (wr_data == CODE_UNL1);
        hit_unl2 = (wr_addr == UNL_ADDR_B) && (wr_data == CODE_UNL2);
        at_cmd   = (wr_addr == UNL_ADDR_A);
        in_boot  = (wr_addr <= BOOT_LAST);
    end

    // Sequence tracker and command outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            prog_start  <= 1'b0;
            prog_addr   <= '0;
            prog_data   <= '0;
            erase_start <= 1'b0;
            id_mode     <= 1'b0;
            boot_locked <= 1'b0;
        end else begin
            prog_start  <= 1'b0;
            erase_start <= 1'b0;
            if (wr_stb && !busy) begin
                state <= ST_IDLE;
                case (state)
                    ST_IDLE: begin
                        if (hit_unl1)
                            state <= ST_UNL1;
                        else if (id_mode && wr_data == CODE_IDOUT)
                            id_mode <= 1'b0;
                    end
                    ST_UNL1: if (hit_unl2) state <= ST_UNL2;
                    ST_UNL2: begin
                        if (at_cmd) begin
                            case (wr_data)
                                CODE_PROG:  state   <= ST_PROG;
                                CODE_IDIN:  id_mode <= 1'b1;
                                CODE_IDOUT: id_mode <= 1'b0;
                                CODE_EXT:   state   <= ST_ERS3;
                                default:    state   <= ST_IDLE;
                            endcase
                        end
                    end
                    ST_PROG: begin
                        if (!(boot_locked && in_boot)) begin
                            prog_start <= 1'b1;
                            prog_addr  <= wr_addr;
                            prog_data  <= wr_data;
                        end
                    end
                    ST_ERS3: if (hit_unl1) state <= ST_ERS4;
                    ST_ERS4: if (hit_unl2) state <= ST_ERS5;
                    ST_ERS5: begin
                        if (at_cmd && wr_data == CODE_ERASE) erase_start <= 1'b1;
                        if (at_cmd && wr_data == CODE_LOCK)  boot_locked <= 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/flash_id_read.sv
// Supplies identification bytes during bus reads in identification mode.
// Assumes the caller qualifies reads; output is zero when not driving.
module flash_id_read #(
    parameter int                ADDR_W = 16,
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] MFR_ID = 8'h1F,
    parameter logic [DATA_W-1:0] DEV_ID = 8'h03
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              id_mode,
    input  logic              boot_locked,
    output logic [DATA_W-1:0] id_dout,
    output logic              id_dout_en
);

    // Read qualifier and identification byte select
    always_comb begin
        id_dout_en = id_mode && !ce_n && !oe_n && we_n;
        id_dout    = '0;
        if (id_dout_en) begin
            case (addr)
                ADDR_W'(0): id_dout = MFR_ID;
                ADDR_W'(1): id_dout = DEV_ID;
                ADDR_W'(2): id_dout = DATA_W'(boot_locked);
                default:    id_dout = '0;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command decoder: write capture, sequence tracker and
// identification read path. Assumes bus strobes are synchronous to clk
// and that a separate engine performs program/erase and drives busy.
module flash_cmd_decoder #(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] UNL_ADDR_A = 16'h5555,
    parameter logic [ADDR_W-1:0] UNL_ADDR_B = 16'h2AAA,
    parameter logic [ADDR_W-1:0] BOOT_LAST  = 16'h1FFF,
    parameter logic [DATA_W-1:0] MFR_ID     = 8'h1F,
    parameter logic [DATA_W-1:0] DEV_ID     = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              busy,
    output logic              prog_start,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_start,
    output logic              id_mode,
    output logic              boot_locked,
    output logic [DATA_W-1:0] id_dout,
    output logic              id_dout_en
);

    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    flash_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .addr    (addr),
        .din     (din),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    flash_seq_fsm #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .UNL_ADDR_A (UNL_ADDR_A),
        .UNL_ADDR_B (UNL_ADDR_B),
        .BOOT_LAST  (BOOT_LAST)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .busy        (busy),
        .prog_start  (prog_start),
        .prog_addr   (prog_addr),
        .prog_data   (prog_data),
        .erase_start (erase_start),
        .id_mode     (id_mode),
        .boot_locked (boot_locked)
    );

    flash_id_read #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .MFR_ID (MFR_ID),
        .DEV_ID (DEV_ID)
    ) u_id (
        .ce_n        (ce_n),
        .oe_n        (oe_n),
        .we_n        (we_n),
        .addr        (addr),
        .id_mode     (id_mode),
        .boot_locked (boot_locked),
        .id_dout     (id_dout),
        .id_dout_en  (id_dout_en)
    );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
// Property checker for flash_cmd_decoder, attached with bind.
// Assumes the default boot boundary parameter of the top module.
module flash_cmd_decoder_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BOOT_LAST = 16'h1FFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              prog_start,
    input logic [ADDR_W-1:0] prog_addr,
    input logic              erase_start,
    input logic              id_mode,
    input logic              boot_locked,
    input logic              id_dout_en
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!id_mode && !boot_locked && !prog_start && !erase_start));

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_start && erase_start));

    // R4
    prog_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start);

    // R6
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_locked |=> boot_locked);

    // R7
    boot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !($past(boot_locked) && prog_addr <= BOOT_LAST));

    // R8
    id_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_dout_en |-> id_mode);

    // R11
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start || erase_start) |-> !$past(busy));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
    .ADDR_W    (ADDR_W),
    .BOOT_LAST (BOOT_LAST)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .prog_start  (prog_start),
    .prog_addr   (prog_addr),
    .erase_start (erase_start),
    .id_mode     (id_mode),
    .boot_locked (boot_locked),
    .id_dout_en  (id_dout_en)
);

// File: tb/test_flash_cmd_decoder.sv
// Self-checking bench: a vector table of bus cycles, then directed tests.
module test_flash_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  din = '0;
    logic        busy = 1'b0;
    logic        prog_start;
    logic [15:0] prog_addr;
    logic [7:0]  prog_data;
    logic        erase_start;
    logic        id_mode;
    logic        boot_locked;
    logic [7:0]  id_dout;
    logic        id_dout_en;

    int checks = 0;
    int errors = 0;
    int prog_cnt = 0;
    int erase_cnt = 0;
    logic [15:0] last_pa = '0;
    logic [7:0]  last_pd = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_decoder i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .busy(busy),
        .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_start(erase_start), .id_mode(id_mode), .boot_locked(boot_locked),
        .id_dout(id_dout), .id_dout_en(id_dout_en)
    );

    // Count request pulses away from the active edge
    always @(negedge clk) begin
        if (prog_start) begin
            prog_cnt <= prog_cnt + 1;
            last_pa  <= prog_addr;
            last_pd  <= prog_data;
        end
        if (erase_start) erase_cnt <= erase_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d, input logic oe = 1'b1);
        @(negedge clk);
        addr = a; din = d; oe_n = oe; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        d = id_dout; en = id_dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic unlock(input logic [7:0] code);
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h5555, code);
    endtask

    task automatic six(input logic [7:0] last);
        unlock(8'h80);
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h5555, last);
    endtask

    // Vector fields: {is_read, addr[15:0], data[7:0], expected enable}
    localparam int NV = 11;
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, 16'h0000, 8'h00, 1'b0},
        {1'b0, 16'h5555, 8'hAA, 1'b0},
        {1'b0, 16'h2AAA, 8'h55, 1'b0},
        {1'b0, 16'h5555, 8'h90, 1'b0},
        {1'b1, 16'h0000, 8'h1F, 1'b1},
        {1'b1, 16'h0001, 8'h03, 1'b1},
        {1'b1, 16'h0002, 8'h00, 1'b1},
        {1'b1, 16'h0005, 8'h00, 1'b1},
        {1'b0, 16'h1234, 8'hF0, 1'b0},
        {1'b1, 16'h0001, 8'h00, 1'b0},
        {1'b1, 16'h0000, 8'h00, 1'b0}
    };

    initial begin
        logic [7:0] rd;
        logic       en;
        int         pc;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!id_mode && !boot_locked && !prog_start && !erase_start && !id_dout_en,
            "R1", {id_mode, boot_locked, prog_start, erase_start}, 0);
        rst_n = 1'b1;

        // R8 R9 table walk: identification entry, reads, single-write exit
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][25]) begin
                bus_rd(VEC[i][24:9], rd, en);
                chk(en == VEC[i][0] && rd == VEC[i][8:1], "R8/R9 table",
                    {en, rd}, {VEC[i][0], VEC[i][8:1]});
            end else begin
                bus_wr(VEC[i][24:9], VEC[i][8:1]);
            end
        end

        // R4 plain program
        unlock(8'hA0);
        bus_wr(16'h8001, 8'h3C);
        chk(prog_cnt == 1 && last_pa == 16'h8001 && last_pd == 8'h3C, "R4",
            {prog_cnt, last_pa, last_pd}, {32'd1, 16'h8001, 8'h3C});

        // R2 address from first window cycle, data from last
        unlock(8'hA0);
        @(negedge clk);
        addr = 16'h4000; din = 8'h11; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        addr = 16'h7777; din = 8'h22;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(prog_cnt == 2 && last_pa == 16'h4000 && last_pd == 8'h22, "R2",
            {last_pa, last_pd}, {16'h4000, 8'h22});

        // R3 write with oe_n low is not a write
        unlock(8'hA0);
        bus_wr(16'h9000, 8'h01, 1'b0);
        chk(prog_cnt == 2, "R3 no pulse", prog_cnt, 2);
        bus_wr(16'h9002, 8'h02);
        chk(prog_cnt == 3 && last_pa == 16'h9002, "R3 sequence held",
            last_pa, 16'h9002);

        // R5 chip erase
        six(8'h10);
        chk(erase_cnt == 1 && prog_cnt == 3, "R5", erase_cnt, 1);

        // R10 broken pattern returns to idle
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h5555, 8'hA0);
        bus_wr(16'h0100, 8'h12);
        chk(prog_cnt == 3, "R10 no program", prog_cnt, 3);
        six(8'h33);
        chk(erase_cnt == 1 && !boot_locked, "R10 bad last code", erase_cnt, 1);

        // R11 busy: writes ignored, tracker keeps its place
        bus_wr(16'h5555, 8'hAA);
        bus_wr(16'h2AAA, 8'h55);
        busy = 1'b1;
        bus_wr(16'h0000, 8'h77);
        bus_wr(16'h5555, 8'h90);
        chk(!id_mode, "R11 ignored while busy", id_mode, 0);
        busy = 1'b0;
        bus_wr(16'h5555, 8'hA0);
        bus_wr(16'hA000, 8'h5A);
        chk(prog_cnt == 4 && last_pa == 16'hA000, "R11 place kept", prog_cnt, 4);

        // R9 three-write exit
        unlock(8'h90);
        chk(id_mode, "R9 entry", id_mode, 1);
        unlock(8'hF0);
        chk(!id_mode, "R9 three-write exit", id_mode, 0);

        // R6 lockout
        six(8'h40);
        chk(boot_locked && erase_cnt == 1, "R6 lock set", boot_locked, 1);
        unlock(8'h90);
        bus_rd(16'h0002, rd, en);
        chk(en && rd == 8'h01, "R8 lock status read", rd, 1);
        busy = 1'b1;
        bus_rd(16'h0000, rd, en);
        chk(en && rd == 8'h1F, "R11 read while busy", rd, 8'h1F);
        busy = 1'b0;
        bus_wr(16'h0000, 8'hF0);

        // R7 boot-sector program dropped, main array accepted
        pc = prog_cnt;
        unlock(8'hA0);
        bus_wr(16'h1FFF, 8'h00);
        chk(prog_cnt == pc, "R7 boot dropped", prog_cnt, pc);
        unlock(8'hA0);
        bus_wr(16'h2000, 8'h0F);
        chk(prog_cnt == pc + 1 && last_pa == 16'h2000, "R7 main accepted",
            last_pa, 16'h2000);

        // R6 lock persists through erase and mode changes
        six(8'h10);
        unlock(8'h90);
        unlock(8'hF0);
        chk(boot_locked && erase_cnt == 2, "R6 sticky", boot_locked, 1);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(negedge clk);
        if (!done) chk(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule